// File: doc/BRIEF.md
# Byte SPI Master

A serial peripheral interface master that moves one 8-bit byte per transfer between a software-facing register port and an external slave. Software configures the serial clock polarity, the bit order, separate transmit and receive enables and automatic slave-select. It programs a clock divider and writes a byte to start a transfer. A received byte is read back through the same port. Both transmit and receive hold one byte.

Four sticky status flags report completion and buffer conditions: transmit holding register empty, receive overrun, transfer done and receive data ready. Each flag has its own enable, and the enabled flags drive one shared interrupt line. Reading the status register clears all four flags. The serial clock is derived from the block's own clock by an even divisor, programmed in steps of four.

Register map at `addr_i`: 0 control, 1 interrupt enables, 2 divider, 3 data (write: transmit byte, read: received byte), 4 status. Reads are combinational on `rdata_o`.

Top module: `spi_byte_master`

## Requirements
- R1: After reset `sclk_o` is 0, `sel_n_o` is 1, `irq_o` is 0, the status register reads 0x00 and the divider register reads 0x04.
- R2: Control bit 0 sets the clock polarity. Each data bit is driven on `mosi_o` at the edge that leaves the idle level and stays stable until the edge that returns to it. `miso_i` is sampled on the return edge. With polarity 0 this is drive on rising and sample on falling; with polarity 1 it is drive on falling and sample on rising.
- R3: Control bit 1 selects bit order: 0 sends and receives the MSB first, 1 sends and receives the LSB first. Every transfer is 8 bits.
- R4: Divider bits [7:2] times 4 is the serial clock period in `clk_i` cycles, so each half period is bits [7:2] times 2. Bits [1:0] are ignored, and a zero in bits [7:2] acts as a divisor of 4.
- R5: Control bit 2 is the transmit enable. While it is 0, no transfer starts, a pending byte waits, and `sclk_o` rests at the idle level set by the polarity. Clearing it during a byte abandons that byte.
- R6: Control bit 3 is the receive enable. While it is 0, a finished byte leaves the received-data register, the ready flag and the overrun flag untouched. The done flag is still set.
- R7: While control bit 4 is 1 at the start of a byte, `sel_n_o` goes low one half period before the first clock edge and returns high after the eighth bit, for each byte. While it is 0, `sel_n_o` stays high.
- R8: Clearing control bit 4 during a byte keeps `sel_n_o` low until that byte ends. It then stays high.
- R9: Writing the data register loads a one-byte holding register. When the engine is idle and transmit is enabled, the byte moves to the shift register and status bit 0 (transmit empty) sets.
- R10: Status bit 1 (overrun) sets when a byte completes with receive enabled while the previous received byte is still unread. The new byte replaces the old one. Status bit 3 marks received data ready, and status bit 2 marks transfer done.
- R11: A read of the status register returns the flags and clears all four, unless a flag's set event falls in the same cycle, in which case that flag stays set.
- R12: `irq_o` is high whenever a status bit is set together with the interrupt-enable bit at the same position in register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, source of the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register select |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on status and data) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt request |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| sel_n_o | output | 1 | Slave select, active low |

## Verification
On every cycle, the assertions check several rules. The engine drops to idle once transmit is disabled, and the select line is high whenever the engine is idle. Serial clock edges are never back to back. A status read clears the flags unless a set event coincides with it. Overrun rises only over an unread byte, and the interrupt only fires with a flag set. Some behaviour only the bench scenarios can show. These are the bit values and order on the data lines, the measured half period for each divider value, select staying low through a mid-byte disable, and the combined flag values after back-to-back bytes.

// File: rtl/spi_byte_master_pkg.sv
package spi_byte_master_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int unsigned C_CPOL = 0;
  localparam int unsigned C_LSB  = 1;
  localparam int unsigned C_TXEN = 2;
  localparam int unsigned C_RXEN = 3;
  localparam int unsigned C_SEL  = 4;
  localparam int unsigned CTRL_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_END} eng_state_e;

  typedef struct packed {
    logic rxf;
    logic done;
    logic ovr;
    logic txe;
  } flags_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-3:0] step, step_eff;
  logic [DIV_W-1:0] half, cnt_q;

  assign step     = div_i[DIV_W-1:2];
  assign step_eff = (step == '0) ? {{(DIV_W-3){1'b0}}, 1'b1} : step;
  assign half     = {1'b0, step_eff, 1'b0};
  assign tick_o   = run_i && (cnt_q == half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_byte_master_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tx_en_i,
  input  logic              tick_i,
  input  logic              cpol_i,
  input  logic              lsb_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              sel_n_o
);
  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  eng_state_e        state_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic              sclk_q, lsb_q, sel_q, mosi_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sclk_q  <= 1'b0;
      lsb_q   <= 1'b0;
      sel_q   <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!tx_en_i) begin
        state_q <= ST_IDLE;  // abandon the byte, clock parks
      end else begin
        case (state_q)
          ST_IDLE: if (start_i) begin
            state_q <= ST_RUN;
            edge_q  <= '0;
            tx_sh_q <= tx_byte_i;
            sclk_q  <= cpol_i;
            lsb_q   <= lsb_i;
            sel_q   <= sel_i;
          end
          ST_RUN: if (tick_i) begin
            sclk_q <= ~sclk_q;
            if (!edge_q[0]) begin  // leading edge: drive
              mosi_o_drive(tx_sh_q, lsb_q);
            end else begin         // trailing edge: sample
              rx_sh_q <= lsb_q ? {miso_i, rx_sh_q[DATA_W-1:1]}
                               : {rx_sh_q[DATA_W-2:0], miso_i};
            end
            if (edge_q == LAST_EDGE) state_q <= ST_END;
            edge_q <= edge_q + 1'b1;
          end
          ST_END: if (tick_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  task automatic mosi_o_drive(input logic [DATA_W-1:0] sh, input logic lsb);
    mosi_q  <= lsb ? sh[0] : sh[DATA_W-1];
    tx_sh_q <= lsb ? (sh >> 1) : (sh << 1);
  endtask

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rx_byte_o = rx_sh_q;
  assign sclk_o    = (busy_o && tx_en_i) ? sclk_q : cpol_i;
  assign mosi_o    = mosi_q;
  assign sel_n_o   = !(busy_o && sel_q);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_master_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              sel_n_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [3:0]        ien_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_hold_q, rx_buf_q, rx_byte;
  logic              tx_full_q, rx_unread_q;
  flags_t            flags_q, flags_set;
  logic              busy, eng_done, tick, start;
  logic              wr_ctrl, wr_ien, wr_div, wr_data, rd_data, rd_stat, rx_take;

  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_ien  = wr_en_i && addr_i == A_IEN;
  assign wr_div  = wr_en_i && addr_i == A_DIV;
  assign wr_data = wr_en_i && addr_i == A_DATA;
  assign rd_data = rd_en_i && addr_i == A_DATA;
  assign rd_stat = rd_en_i && addr_i == A_STAT;

  assign start   = !busy && tx_full_q && ctrl_q[C_TXEN];
  assign rx_take = eng_done && ctrl_q[C_RXEN];

  always_comb begin
    flags_set      = '0;
    flags_set.txe  = start;
    flags_set.done = eng_done;
    flags_set.rxf  = rx_take;
    flags_set.ovr  = rx_take && rx_unread_q && !rd_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      ien_q       <= '0;
      div_q       <= DIV_RST;
      tx_hold_q   <= '0;
      tx_full_q   <= 1'b0;
      rx_buf_q    <= '0;
      rx_unread_q <= 1'b0;
      flags_q     <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_ien)  ien_q  <= wdata_i[3:0];
      if (wr_div)  div_q  <= wdata_i[DIV_W-1:0];
      if (wr_data) begin
        tx_hold_q <= wdata_i;
        tx_full_q <= 1'b1;
      end else if (start) begin
        tx_full_q <= 1'b0;
      end
      if (rx_take) begin
        rx_buf_q    <= rx_byte;
        rx_unread_q <= 1'b1;
      end else if (rd_data) begin
        rx_unread_q <= 1'b0;
      end
      flags_q <= (rd_stat ? flags_t'('0) : flags_q) | flags_set;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = DATA_W'(ctrl_q);
      A_IEN:   rdata_o = DATA_W'(ien_q);
      A_DIV:   rdata_o = DATA_W'(div_q);
      A_DATA:  rdata_o = rx_buf_q;
      A_STAT:  rdata_o = DATA_W'(flags_q);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(flags_q & ien_q);

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && ctrl_q[C_TXEN]),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_shift_eng #(.DATA_W(DATA_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .tx_en_i   (ctrl_q[C_TXEN]),
    .tick_i    (tick),
    .cpol_i    (ctrl_q[C_CPOL]),
    .lsb_i     (ctrl_q[C_LSB]),
    .sel_i     (ctrl_q[C_SEL]),
    .tx_byte_i (tx_hold_q),
    .miso_i    (miso_i),
    .busy_o    (busy),
    .done_o    (eng_done),
    .rx_byte_o (rx_byte),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .sel_n_o   (sel_n_o)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en,
  input logic       busy,
  input logic       sclk_o,
  input logic       sel_n_o,
  input logic       rd_stat,
  input logic       start,
  input logic       done,
  input logic       rx_unread,
  input logic [3:0] flags,
  input logic       irq_o
);
  a_r5_idle_when_tx_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |=> !busy);

  a_r7_sel_high_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sel_n_o);

  a_r4_edge_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tx_en && $changed(sclk_o)) |=> ($stable(sclk_o) || !busy));

  a_r11_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !start && !done) |=> (flags == 4'b0));

  a_r10_ovr_over_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[1]) |-> $past(rx_unread));

  a_r12_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != 4'b0));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en     (ctrl_q[2]),
  .busy      (busy),
  .sclk_o    (sclk_o),
  .sel_n_o   (sel_n_o),
  .rd_stat   (rd_stat),
  .start     (start),
  .done      (eng_done),
  .rx_unread (rx_unread_q),
  .flags     (flags_q),
  .irq_o     (irq_o)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, sclk_o, mosi_o, sel_n_o;
  logic       miso_i = 1'b0;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] miso_q[$];

  logic       mon_on = 1'b0, cpol_b = 1'b0, lsb_b = 1'b0, sel_b = 1'b0;
  logic       prev_sclk = 1'b0;
  logic [7:0] got, cur_miso;
  int bit_i = 0, bytes_seen = 0, edges = 0, ss_viol = 0, ss_low = 0;
  int cyc = 0, last_edge_cyc = 0, last_gap = 0;

  spi_byte_master u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .sel_n_o(sel_n_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard: acts as slave, compares mosi bytes
  always @(negedge clk_i) begin
    cyc++;
    if (!sel_n_o) ss_low++;
    if (mon_on && sclk_o !== prev_sclk) begin
      edges++;
      last_gap = cyc - last_edge_cyc;
      last_edge_cyc = cyc;
      if (sclk_o != cpol_b) begin
        if (bit_i == 0) cur_miso = (miso_q.size() > 0) ? miso_q.pop_front() : 8'h00;
        miso_i = lsb_b ? cur_miso[bit_i] : cur_miso[7-bit_i];
      end else begin
        got[lsb_b ? bit_i : 7-bit_i] = mosi_o;
        if (sel_b && sel_n_o) ss_viol++;
        bit_i++;
        if (bit_i == 8) begin
          logic [7:0] e;
          bit_i = 0;
          bytes_seen++;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
          check(got === e, "R2 R3 mosi byte", got, e);
        end
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i); #1;
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i); #1;
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i); #1;
    rd_en_i = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    mon_on = 1'b0;
    reg_wr(3'd0, v);
    cpol_b = v[0]; lsb_b = v[1]; sel_b = v[4];
    repeat (2) @(negedge clk_i);
    #1 mon_on = 1'b1;
  endtask

  task automatic send(input logic [7:0] tx, input logic [7:0] rx);
    exp_q.push_back(tx);
    miso_q.push_back(rx);
    reg_wr(3'd3, tx);
  endtask

  task automatic wait_bytes(input int target);
    int t = 0;
    while (bytes_seen < target && t < 20000) begin
      @(negedge clk_i); t++;
    end
    check(bytes_seen >= target, "R9 byte completes", bytes_seen, target);
    repeat (300) @(negedge clk_i);
  endtask

  logic [7:0] d;

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", bytes_seen, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    check(sel_n_o == 1'b1, "R1 sel", sel_n_o, 1);
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    reg_rd(3'd4, d); check(d == 8'h00, "R1 status", d, 8'h00);
    reg_rd(3'd2, d); check(d == 8'h04, "R1 divider", d, 8'h04);

    // R2 polarity 0, MSB first, select on
    set_ctrl(8'h1C);
    ss_low = 0;
    send(8'hA5, 8'h3C);
    wait_bytes(1);
    reg_rd(3'd3, d); check(d == 8'h3C, "R2 rx msb cpol0", d, 8'h3C);
    check(last_gap == 2, "R4 default half period", last_gap, 2);
    check(ss_viol == 0, "R7 sel low during bits", ss_viol, 0);
    check(ss_low > 0 && sel_n_o == 1'b1, "R7 sel pulsed and released", sel_n_o, 1);

    // R3 LSB first
    set_ctrl(8'h1E);
    send(8'h1E, 8'hC3);
    wait_bytes(2);
    reg_rd(3'd3, d); check(d == 8'hC3, "R3 rx lsb first", d, 8'hC3);

    // R2 polarity 1
    set_ctrl(8'h1D);
    check(sclk_o == 1'b1, "R2 idle high cpol1", sclk_o, 1);
    send(8'h5A, 8'hA6);
    wait_bytes(3);
    reg_rd(3'd3, d); check(d == 8'hA6, "R2 rx cpol1", d, 8'hA6);

    // R4 divider
    reg_wr(3'd2, 8'h24);
    send(8'h96, 8'h69);
    wait_bytes(4);
    check(last_gap == 18, "R4 div 0x24", last_gap, 18);
    reg_wr(3'd2, 8'h27);
    send(8'h0F, 8'hF0);
    wait_bytes(5);
    check(last_gap == 18, "R4 low bits ignored", last_gap, 18);
    reg_wr(3'd2, 8'h01);
    send(8'hE7, 8'h18);
    wait_bytes(6);
    check(last_gap == 2, "R4 zero step acts as 4", last_gap, 2);

    // R8 select cleared mid-byte
    set_ctrl(8'h1C);
    reg_wr(3'd2, 8'h24);
    send(8'hC6, 8'h6C);
    while (bit_i < 3) @(negedge clk_i);
    reg_wr(3'd0, 8'h0C);
    sel_b = 1'b0;
    @(negedge clk_i);
    check(sel_n_o == 1'b0, "R8 sel held during byte", sel_n_o, 0);
    wait_bytes(7);
    check(sel_n_o == 1'b1, "R8 sel released after byte", sel_n_o, 1);

    // R7 select disabled: stays high
    reg_wr(3'd2, 8'h04);
    ss_low = 0;
    send(8'h33, 8'hCC);
    wait_bytes(8);
    check(ss_low == 0, "R7 sel stays high when off", ss_low, 0);

    // R5 transmit disabled
    reg_rd(3'd3, d);
    reg_rd(3'd4, d);
    set_ctrl(8'h08);
    edges = 0;
    send(8'h3C, 8'h99);
    repeat (200) @(negedge clk_i);
    check(edges == 0, "R5 no clock edges", edges, 0);
    check(sclk_o == 1'b0, "R5 clock parked", sclk_o, 0);
    reg_rd(3'd4, d); check(d == 8'h00, "R5 R9 no start", d, 8'h00);
    reg_wr(3'd0, 8'h0C);
    repeat (6) @(negedge clk_i);
    reg_rd(3'd4, d); check(d[0] == 1'b1, "R9 txe after load", d, 1);
    wait_bytes(9);
    reg_rd(3'd3, d); check(d == 8'h99, "R5 rx after enable", d, 8'h99);

    // R6 receive disabled
    reg_rd(3'd4, d);
    reg_wr(3'd0, 8'h04);
    send(8'h55, 8'h0F);
    wait_bytes(10);
    reg_rd(3'd4, d); check(d == 8'h05, "R6 only txe and done", d, 8'h05);
    reg_rd(3'd3, d); check(d == 8'h99, "R6 rx data kept", d, 8'h99);

    // R10 overrun
    reg_wr(3'd0, 8'h0C);
    send(8'h12, 8'h11);
    repeat (10) @(negedge clk_i);
    send(8'h34, 8'h22);
    wait_bytes(12);
    reg_rd(3'd4, d); check(d == 8'h0F, "R10 overrun flags", d, 8'h0F);
    reg_rd(3'd3, d); check(d == 8'h22, "R10 newer byte kept", d, 8'h22);
    reg_rd(3'd4, d); check(d == 8'h00, "R11 read cleared", d, 8'h00);

    // R12 interrupt
    reg_wr(3'd1, 8'h04);
    send(8'h77, 8'h88);
    wait_bytes(13);
    check(irq_o == 1'b1, "R12 irq on done", irq_o, 1);
    reg_rd(3'd4, d);
    @(negedge clk_i);
    check(irq_o == 1'b0, "R12 R11 irq cleared by read", irq_o, 0);
    reg_wr(3'd1, 8'h00);
    send(8'h78, 8'h87);
    wait_bytes(14);
    check(irq_o == 1'b0, "R12 masked", irq_o, 0);
    reg_rd(3'd4, d); check(d != 8'h00, "R12 flags set while masked", d, 8'h0F);

    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule